// File: doc/BRIEF.md
# Dual-Quad SPI Flash Host Sequencer

This block is the host side of a link to two quad SPI flash dies that work in parallel. The two dies share one 8-bit IO bus. Each die has its own serial clock and its own active-low select, and the block drives each pair in lockstep. A requester presents one command at a time. The command carries an 8-bit opcode, an address of 24 or 32 bits, a count of dummy clocks, a data direction and a byte length. The block then plays out the whole transaction in single data rate.

The opcode goes out serially on the lowest line of each quad group, so both dies decode the same instruction. The address follows one nibble per clock, and the same nibble appears on both quad groups. Optional dummy clocks come next, with the bus released. Data then moves one byte per clock across all eight lines. The lower quad group carries the low nibble and the upper group carries the high nibble.

The serial clock runs at half the system clock. Outputs are launched on the falling serial edge and read data is captured on the rising one. Write bytes are pulled with a one-cycle take strobe. Read bytes are handed out with a one-cycle valid strobe. A busy level and a done pulse tell the requester when the command has finished.

Top module: `dqspi_host_seq`

## Requirements
- R1: After reset both selects are high, both serial clocks are low, no IO line is driven, and busy and done are low.
- R2: Both selects fall before the first rising serial edge of a command and stay low until its last serial clock. Both clocks and both selects always carry identical values. The serial clock is low whenever the selects are high. Each command gives exactly 8 + address clocks + dummy + length rising edges.
- R3: The opcode takes 8 serial clocks, most significant bit first. During those clocks only IO0 and IO4 are driven (output enable 8'h11), and both carry the same bit.
- R4: The address goes out most significant nibble first: 6 clocks when req_wide is 0 (bits 23:0) and 8 clocks when it is 1. Each clock drives all eight lines, with IO7–IO4 equal to IO3–IO0.
- R5: IO values and output enables change only at a falling serial edge. They are stable while the serial clock is high.
- R6: The req_dummy count of serial clocks, with every IO line released, is placed between the address and the data. A count of zero inserts none.
- R7: For a write, each data clock drives one byte on IO7–IO0, with bit i on line i (low nibble on IO3–IO0, high nibble on IO7–IO4). wr_ready pulses once for each byte taken from wr_data.
- R8: For a read, all IO lines are released during the data clocks. The byte on io_in is captured at each rising serial edge and presented on rd_data with a one-cycle rd_valid pulse, in order.
- R9: busy is high from acceptance until the cycle after done. done is a single-cycle pulse in the cycle in which the selects return high. The selects stay high for at least two system clocks between commands.
- R10: A request with req_len of zero ends right after the address and any dummy clocks, with no data clocks.
- R11: A request presented while a command is in progress is ignored. It causes no extra select fall and does not change the opcode being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request, accepted when idle |
| req_opcode | input | 8 | Instruction byte |
| req_addr | input | 32 | Address, low 24 bits used in narrow mode |
| req_wide | input | 1 | 1 selects 32-bit address, 0 selects 24-bit |
| req_dummy | input | 4 | Number of dummy serial clocks |
| req_write | input | 1 | 1 for write data, 0 for read data |
| req_len | input | 8 | Number of data bytes, zero allowed |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_data | input | 8 | Write byte offered to the block |
| wr_ready | output | 1 | Write byte taken this cycle |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | rd_data valid this cycle |
| sck1 | output | 1 | Serial clock, first die |
| sck2 | output | 1 | Serial clock, second die |
| cs1_n | output | 1 | Active-low select, first die |
| cs2_n | output | 1 | Active-low select, second die |
| io_out | output | 8 | IO bus output values |
| io_oe | output | 8 | Per-line output enable |
| io_in | input | 8 | IO bus input values |

## Verification
Commands are issued back to back with a mix of address widths, dummy counts, directions and lengths. Narrow and wide addresses show whether the nibble count and start position are right. Dummy counts of zero and nonzero show whether the release window is placed and sized correctly. A read of a byte pattern that changes every clock shows any capture on the wrong edge or any skipped byte. A zero-length command shows whether the block ends cleanly without a data phase. A second request injected in the middle of a command shows whether requests are ignored while busy.

// File: rtl/dqspi_pkg.sv
package dqspi_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_GAP
  } phase_e;

  // serial clocks spent on the address
  function automatic logic [5:0] addr_clocks(input logic wide);
    return wide ? 6'd8 : 6'd6;
  endfunction

  // left-justify the address so the first nibble sits in bits 31:28
  function automatic logic [31:0] addr_align(input logic [31:0] a, input logic wide);
    return wide ? a : {a[23:0], 8'h00};
  endfunction

  // phase following the current one once its last clock has gone out
  function automatic phase_e next_phase(input phase_e ph, input logic has_dum,
                                        input logic has_data);
    case (ph)
      PH_CMD:   return PH_ADDR;
      PH_ADDR:  return has_dum ? PH_DUMMY : (has_data ? PH_DATA : PH_GAP);
      PH_DUMMY: return has_data ? PH_DATA : PH_GAP;
      default:  return PH_GAP;
    endcase
  endfunction

endpackage

// File: rtl/dqspi_seq_fsm.sv
module dqspi_seq_fsm
  import dqspi_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DUM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [7:0]       req_opcode,
  input  logic [31:0]      req_addr,
  input  logic             req_wide,
  input  logic [DUM_W-1:0] req_dummy,
  input  logic             req_write,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output phase_e           phase,
  output logic             op_msb,
  output logic [3:0]       addr_nib,
  output logic [7:0]       data_byte,
  output logic             is_write,
  output logic             sck,
  output logic             cs_n,
  output logic             busy,
  output logic             done,
  output logic             ev_rise,
  output logic             ev_fall
);

  localparam int CNT_W = (LEN_W > 5) ? LEN_W : 5;

  logic [CNT_W-1:0] cnt;
  logic [7:0]       op_sh;
  logic [31:0]      addr_sh;
  logic [7:0]       dq;
  logic             wr_q, wide_q, sck_q, cs_q, done_q;
  logic [DUM_W-1:0] dum_q;
  logic [LEN_W-1:0] len_q;

  logic   active, last_item;
  phase_e tgt;

  assign active    = phase inside {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA};
  assign ev_rise   = active && !sck_q;
  assign ev_fall   = active && sck_q;
  assign last_item = (cnt == '0);
  assign tgt       = next_phase(phase, dum_q != '0, len_q != '0);

  // a write byte is taken on the fall that opens each data clock
  assign wr_ready = ev_fall && wr_q &&
                    ((phase == PH_DATA && !last_item) ||
                     (phase != PH_DATA && last_item && tgt == PH_DATA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      op_sh   <= '0;
      addr_sh <= '0;
      dq      <= '0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      dum_q   <= '0;
      len_q   <= '0;
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            phase   <= PH_CMD;
            cnt     <= CNT_W'(7);
            op_sh   <= req_opcode;
            addr_sh <= addr_align(req_addr, req_wide);
            wr_q    <= req_write;
            wide_q  <= req_wide;
            dum_q   <= req_dummy;
            len_q   <= req_len;
            cs_q    <= 1'b0;
          end
        end
        PH_GAP: phase <= PH_IDLE;
        default: begin
          sck_q <= ~sck_q;
          if (sck_q) begin
            if (!last_item) begin
              cnt <= cnt - CNT_W'(1);
              if (phase == PH_CMD)  op_sh   <= {op_sh[6:0], 1'b0};
              if (phase == PH_ADDR) addr_sh <= {addr_sh[27:0], 4'h0};
              if (phase == PH_DATA && wr_q) dq <= wr_data;
            end else begin
              phase <= tgt;
              unique case (tgt)
                PH_ADDR:  cnt <= CNT_W'(addr_clocks(wide_q) - 6'd1);
                PH_DUMMY: cnt <= CNT_W'(dum_q) - CNT_W'(1);
                PH_DATA: begin
                  cnt <= CNT_W'(len_q) - CNT_W'(1);
                  if (wr_q) dq <= wr_data;
                end
                default: begin
                  cs_q   <= 1'b1;
                  done_q <= 1'b1;
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  assign op_msb    = op_sh[7];
  assign addr_nib  = addr_sh[31:28];
  assign data_byte = dq;
  assign is_write  = wr_q;
  assign sck       = sck_q;
  assign cs_n      = cs_q;
  assign busy      = (phase != PH_IDLE);
  assign done      = done_q;

  // R2: select held low through every active phase
  p_cs_low_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !cs_q);

  // R9: the select rises only together with the completion pulse
  p_done_with_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |-> done_q);

  // R11: a new command starts only from idle
  p_start_from_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_CMD) |-> $past(phase) == PH_IDLE);

endmodule

// File: rtl/dqspi_lane_mux.sv
module dqspi_lane_mux
  import dqspi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_e     phase,
  input  logic       op_msb,
  input  logic [3:0] addr_nib,
  input  logic [7:0] data_byte,
  input  logic       is_write,
  output logic [7:0] io_out,
  output logic [7:0] io_oe
);

  localparam int GROUPS = 2;
  localparam int GW     = 4;

  logic [GW-1:0] grp_out [GROUPS];
  logic [GW-1:0] grp_oe  [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_quad
    always_comb begin
      grp_out[g] = '0;
      grp_oe[g]  = '0;
      unique case (phase)
        PH_CMD: begin
          grp_out[g] = {3'b000, op_msb};
          grp_oe[g]  = 4'b0001;
        end
        PH_ADDR: begin
          grp_out[g] = addr_nib;
          grp_oe[g]  = 4'hF;
        end
        PH_DATA: begin
          grp_out[g] = data_byte[GW*g +: GW];
          grp_oe[g]  = is_write ? 4'hF : 4'h0;
        end
        default: ;
      endcase
    end
  end

  assign io_out = {grp_out[1], grp_out[0]};
  assign io_oe  = {grp_oe[1], grp_oe[0]};

  // R4: both quad groups carry the same address nibble
  p_addr_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_ADDR |-> io_out[3:0] == io_out[7:4]);

  // R3: instruction bit mirrored on the first line of each group
  p_cmd_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_CMD |-> (io_out[0] == io_out[4]) && (io_oe[7:4] == io_oe[3:0]));

  // R8, R6: bus released while the dies may drive it
  p_read_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DUMMY || (phase == PH_DATA && !is_write)) |-> io_oe == 8'h00);

endmodule

// File: rtl/dqspi_rx_capture.sv
module dqspi_rx_capture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_en,
  input  logic [7:0] io_in,
  output logic [7:0] rd_data,
  output logic       rd_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= sample_en;
      if (sample_en) rd_data <= io_in;
    end
  end

  // R8: each capture yields a single-cycle strobe
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(sample_en));

endmodule

// File: rtl/dqspi_host_seq.sv
module dqspi_host_seq
  import dqspi_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int DUM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [7:0]       req_opcode,
  input  logic [31:0]      req_addr,
  input  logic             req_wide,
  input  logic [DUM_W-1:0] req_dummy,
  input  logic             req_write,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             sck1,
  output logic             sck2,
  output logic             cs1_n,
  output logic             cs2_n,
  output logic [7:0]       io_out,
  output logic [7:0]       io_oe,
  input  logic [7:0]       io_in
);

  phase_e     phase;
  logic       op_msb, is_write, sck, cs_n, ev_rise, ev_fall;
  logic [3:0] addr_nib;
  logic [7:0] data_byte;
  logic       sample_en;

  dqspi_seq_fsm #(.LEN_W(LEN_W), .DUM_W(DUM_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_opcode (req_opcode),
    .req_addr   (req_addr),
    .req_wide   (req_wide),
    .req_dummy  (req_dummy),
    .req_write  (req_write),
    .req_len    (req_len),
    .wr_data    (wr_data),
    .wr_ready   (wr_ready),
    .phase      (phase),
    .op_msb     (op_msb),
    .addr_nib   (addr_nib),
    .data_byte  (data_byte),
    .is_write   (is_write),
    .sck        (sck),
    .cs_n       (cs_n),
    .busy       (busy),
    .done       (done),
    .ev_rise    (ev_rise),
    .ev_fall    (ev_fall)
  );

  dqspi_lane_mux u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .op_msb    (op_msb),
    .addr_nib  (addr_nib),
    .data_byte (data_byte),
    .is_write  (is_write),
    .io_out    (io_out),
    .io_oe     (io_oe)
  );

  assign sample_en = ev_rise && (phase == PH_DATA) && !is_write;

  dqspi_rx_capture u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .io_in     (io_in),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  assign sck1  = sck;
  assign sck2  = sck;
  assign cs1_n = cs_n;
  assign cs2_n = cs_n;

  // R2: no serial clock activity while deselected
  p_idle_sck_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs1_n |-> !sck1);

  // R5: the bus holds across every rising serial edge
  p_io_hold_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise |=> $stable(io_out) && $stable(io_oe));

  // R5: the falling edge always follows a rise one cycle later
  p_fall_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise |=> ev_fall);

  // R9: completion only with the selects high
  p_done_cs_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs1_n && cs2_n);

endmodule

// File: tb/tb_dqspi_host_seq.sv
module tb_dqspi_host_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [7:0]  req_opcode = '0;
  logic [31:0] req_addr = '0;
  logic        req_wide = 1'b0;
  logic [3:0]  req_dummy = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_len = '0;
  logic        busy, done, wr_ready, rd_valid;
  logic [7:0]  wr_data, rd_data;
  logic        sck1, sck2, cs1_n, cs2_n;
  logic [7:0]  io_out, io_oe;
  logic [7:0]  io_in = 8'h00;

  dqspi_host_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_addr(req_addr), .req_wide(req_wide), .req_dummy(req_dummy),
    .req_write(req_write), .req_len(req_len), .busy(busy), .done(done),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .sck1(sck1), .sck2(sck2), .cs1_n(cs1_n), .cs2_n(cs2_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rpat(input int k);
    return 8'(k * 43 + 8'h3C);
  endfunction

  // command description shared with the device model
  bit cfg_wide, cfg_write;
  int cfg_dummy, cfg_len;

  logic [7:0] wbuf [256];
  int wr_idx = 0;
  assign wr_data = wbuf[wr_idx[7:0]];
  always @(posedge clk) if (wr_ready) wr_idx <= wr_idx + 1;

  logic [7:0] exp_wq [$];
  logic [7:0] exp_rq [$];

  // device model
  int rise_cnt = 0, dev_k = 0, cs_falls = 0;
  logic [7:0]  dev_op = '0;
  logic [31:0] dev_addr = '0;
  logic [7:0]  io_at_rise = '0, oe_at_rise = '0;

  always @(negedge cs1_n) begin
    rise_cnt = 0; dev_k = 0; dev_op = '0; dev_addr = '0;
    cs_falls++;
  end

  always @(posedge sck1) begin
    int nib;
    logic [7:0] e;
    nib = cfg_wide ? 8 : 6;
    io_at_rise = io_out;
    oe_at_rise = io_oe;
    if (rise_cnt < 8) begin
      chk(io_oe == 8'h11, "R3", "opcode lane enables", io_oe, 8'h11);
      chk(io_out[4] == io_out[0], "R3", "opcode mirror", io_out[4], io_out[0]);
      dev_op = {dev_op[6:0], io_out[0]};
    end else if (rise_cnt < 8 + nib) begin
      chk(io_oe == 8'hFF && io_out[7:4] == io_out[3:0], "R4", "address nibble dup",
          {io_oe, io_out}, {8'hFF, io_out[3:0], io_out[3:0]});
      dev_addr = {dev_addr[27:0], io_out[3:0]};
    end else if (rise_cnt < 8 + nib + cfg_dummy) begin
      chk(io_oe == 8'h00, "R6", "dummy release", io_oe, 0);
    end else if (cfg_write) begin
      if (exp_wq.size() == 0) chk(0, "R7", "unexpected write byte", io_out, 0);
      else begin
        e = exp_wq.pop_front();
        chk(io_oe == 8'hFF && io_out == e, "R7", "write byte", {io_oe, io_out}, {8'hFF, e});
      end
    end else begin
      chk(io_oe == 8'h00, "R8", "read release", io_oe, 0);
      dev_k++;
    end
    rise_cnt++;
  end

  always @(negedge sck1) io_in <= rpat(dev_k);

  // read monitor and continuous watchers
  bit pair_bad = 0, stab_bad = 0, done_prev = 0;
  int gap_run = 0, min_gap = 1000;

  always @(negedge clk) begin
    logic [7:0] e;
    if (rst_n) begin
      if (rd_valid) begin
        if (exp_rq.size() == 0) chk(0, "R8", "unexpected read byte", rd_data, 0);
        else begin
          e = exp_rq.pop_front();
          chk(rd_data == e, "R8", "read byte", rd_data, e);
        end
      end
      if (sck1 !== sck2 || cs1_n !== cs2_n || (cs1_n && sck1)) pair_bad = 1;
      if (sck1 && (io_out !== io_at_rise || io_oe !== oe_at_rise)) stab_bad = 1;
      if (done) begin
        chk(cs1_n && cs2_n && !done_prev, "R9", "done pulse with selects high",
            {done_prev, cs1_n, cs2_n}, 3'b011);
      end
      done_prev = done;
      if (cs1_n) gap_run++;
      else begin
        if (gap_run > 0 && cs_falls > 1 && gap_run < min_gap) min_gap = gap_run;
        gap_run = 0;
      end
    end
  end

  task automatic run_cmd(input logic [7:0] op, input logic [31:0] addr, input bit wide,
                         input int dum, input bit wr, input int len, input bit poke);
    int falls0, nib;
    cfg_wide = wide; cfg_write = wr; cfg_dummy = dum; cfg_len = len;
    wr_idx = 0;
    for (int k = 0; k < len; k++) begin
      wbuf[k] = 8'(k * 7 + op);
      if (wr) exp_wq.push_back(wbuf[k]);
      else exp_rq.push_back(rpat(k));
    end
    pair_bad = 0; stab_bad = 0;
    falls0 = cs_falls;
    req_opcode = op; req_addr = addr; req_wide = wide; req_dummy = 4'(dum);
    req_write = wr; req_len = 8'(len); req_valid = 1'b1;
    do @(negedge clk); while (cs1_n);
    req_valid = 1'b0;
    chk(busy, "R9", "busy during command", busy, 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      req_valid = 1'b1; req_opcode = 8'hEE;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    do @(negedge clk); while (!done);
    nib = wide ? 8 : 6;
    chk(dev_op == op, "R3", "opcode msb first", dev_op, op);
    chk(dev_addr == (wide ? addr : {8'h00, addr[23:0]}), "R4", "address value",
        dev_addr, wide ? addr : {8'h00, addr[23:0]});
    chk(rise_cnt == 8 + nib + dum + len, "R2", "serial clock count", rise_cnt,
        8 + nib + dum + len);
    if (len == 0) chk(rise_cnt == 8 + nib + dum, "R10", "no data clocks", rise_cnt, 8 + nib + dum);
    if (wr) chk(exp_wq.size() == 0 && wr_idx == len, "R7", "all write bytes taken", wr_idx, len);
    else chk(exp_rq.size() == 0, "R8", "all read bytes returned", exp_rq.size(), 0);
    chk(!pair_bad, "R2", "clock and select pairing", pair_bad, 0);
    chk(!stab_bad, "R5", "bus stable while clock high", stab_bad, 0);
    if (poke) chk(cs_falls == falls0 + 1, "R11", "request ignored while busy",
                  cs_falls - falls0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) wbuf[k] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cs1_n && cs2_n && !sck1 && !sck2 && io_oe == 0 && !busy && !done, "R1",
        "reset state", {cs1_n, cs2_n, sck1, sck2, busy, done, io_oe}, {6'b110000, 8'h00});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs1_n && !busy, "R1", "idle after reset", {cs1_n, busy}, 2'b10);

    run_cmd(8'h32, 32'h00A1B2C3, 1'b0, 0, 1'b1, 4, 1'b0);   // R7 narrow write
    run_cmd(8'hEC, 32'h89ABCDEF, 1'b1, 6, 1'b0, 5, 1'b0);   // R6 R8 wide read
    run_cmd(8'h6B, 32'hFF123456, 1'b0, 0, 1'b0, 3, 1'b0);   // R8 read, no dummy
    run_cmd(8'h9F, 32'h13572468, 1'b1, 2, 1'b0, 0, 1'b0);   // R10 zero length
    run_cmd(8'h02, 32'h80000001, 1'b1, 0, 1'b1, 1, 1'b1);   // R11 poke while busy
    run_cmd(8'hA5, 32'h0F0F0F0F, 1'b1, 1, 1'b1, 9, 1'b0);   // R7 wide write with dummy

    repeat (3) @(negedge clk);
    chk(min_gap >= 2, "R9", "select high gap", min_gap, 2);
    chk(!busy && cs1_n && io_oe == 0, "R1", "back to idle", {busy, cs1_n, io_oe}, {2'b01, 8'h00});
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule